// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Staged Updates

This block is a register-mapped pulse-width modulation peripheral with several independent channels; the default is four. Each channel has a prescaler. Its period counter advances once every (prescale + 1) input clocks and wraps after a programmable modulus. The channel output is high while the counter is below the programmed duty value and low for the rest of the period.

Software programs a channel through a plain word-addressed bus with a write enable, write data and combinational read data. Prescale and modulus writes only change the staging copies. A duty write captures the staged prescale and modulus together with the new duty as one coherent set. While the channel runs, that set reaches the output only at the end of the running period, so no period mixes old and new settings. Clearing the enable bit does not wait for the period boundary: the output drops at once.

Top module: `multi_pwm`

## Requirements
- R1: The word address is split as follows. Bits [4:3] select the channel, and bits [2:0] select the register: 0 is prescale (8 bits), 1 is modulus (8 bits), 2 is duty (16 bits) and 6 is enable (bit 0 only). These are byte offsets 0x0, 0x4, 0x8 and 0x18 inside a 32-byte window per channel.
- R2: A read returns the last value written to the addressed register, zero-extended to 32 bits. For the enable register this is the enable bit alone.
- R3: Register offsets 3, 4, 5 and 7 read as zero, and writes to them change neither any register nor any output.
- R4: While enabled, a channel repeats a period of (prescale+1)×modulus clocks. The output is high for the first (prescale+1)×min(duty, modulus) clocks of each period and low for the rest.
- R5: A duty of zero keeps the output low for the whole period. A duty greater than or equal to the modulus keeps it high for the whole period.
- R6: Writing prescale or modulus without a following duty write leaves the output waveform unchanged.
- R7: A duty write to a running channel commits the staged prescale, modulus and new duty together, and the running period finishes with the old settings first.
- R8: Clearing the enable bit forces the output low in the cycle after the write, regardless of the position in the period.
- R9: A disabled channel drives low and holds its counters at zero. A commit made while disabled is applied at once, so the first period after enabling starts at count zero and uses the committed values.
- R10: Channels are independent: accesses to one channel do not affect another channel's registers or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe for the addressed register |
| addr | input | 5 | Word address: channel in [4:3], register in [2:0] |
| wdata | input | 16 | Write data, as wide as the widest register |
| rdata | output | 32 | Read data for the current address, zero-extended |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit prescale and modulus, and 16-bit duty. With these values every channel index and every register offset is reachable, and the bench can run full periods of every pattern in its vector table within a few hundred clocks. The small moduli used in the table bring the edge cases of the compare within reach: duty zero, duty equal to the modulus, duty above the modulus, and a one-count period. The 16-bit duty field lets a duty value larger than any modulus be stored and read back.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PRE_W  = 8;
    localparam int MOD_W  = 8;
    localparam int DUTY_W = 16;
    localparam int OFF_W  = 3;
    localparam int RD_W   = 32;

    typedef enum logic [OFF_W-1:0] {
        OFF_PRESCALE = 3'd0,
        OFF_MODULUS  = 3'd1,
        OFF_DUTY     = 3'd2,
        OFF_ENABLE   = 3'd6
    } reg_off_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MOD_W-1:0]  modv;
        logic [DUTY_W-1:0] duty;
    } pwm_cfg_t;

    function automatic logic [RD_W-1:0] zext_rd(input logic [DUTY_W-1:0] v);
        return {{(RD_W-DUTY_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_lim,
    input  logic [MOD_W-1:0] mod_lim,
    output logic [MOD_W-1:0] cnt,
    output logic             boundary
);
    logic [PRE_W-1:0] pre_cnt;
    logic             tick;
    logic             last;

    assign tick     = run && (pre_cnt == pre_lim);
    assign last     = (mod_lim == '0) || (cnt == mod_lim - MOD_W'(1));
    assign boundary = tick && last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            cnt     <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
            if (tick) cnt <= last ? '0 : cnt + MOD_W'(1);
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (run && mod_lim != '0) |-> (cnt < mod_lim));

    // R4
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (pre_cnt <= pre_lim));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0 && pre_cnt == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [OFF_W-1:0]  off,
    input  logic [DUTY_W-1:0] wdata,
    output logic [RD_W-1:0]   rdata,
    output logic              pwm_o
);
    pwm_cfg_t         shadow;
    pwm_cfg_t         staged;
    pwm_cfg_t         active;
    logic             en;
    logic             pending;
    logic [MOD_W-1:0] cnt;
    logic             boundary;

    pwm_timebase u_tb (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .pre_lim  (active.pre),
        .mod_lim  (active.modv),
        .cnt      (cnt),
        .boundary (boundary)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            staged  <= '0;
            active  <= '0;
            en      <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (pending && (!en || boundary)) begin
                active  <= staged;
                pending <= 1'b0;
            end
            if (we) begin
                case (off)
                    OFF_PRESCALE: shadow.pre  <= wdata[PRE_W-1:0];
                    OFF_MODULUS:  shadow.modv <= wdata[MOD_W-1:0];
                    OFF_DUTY: begin
                        shadow.duty <= wdata;
                        staged      <= '{pre: shadow.pre, modv: shadow.modv, duty: wdata};
                        pending     <= 1'b1;
                    end
                    OFF_ENABLE:   en <= wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (off)
            OFF_PRESCALE: rdata = zext_rd(DUTY_W'(shadow.pre));
            OFF_MODULUS:  rdata = zext_rd(DUTY_W'(shadow.modv));
            OFF_DUTY:     rdata = zext_rd(shadow.duty);
            OFF_ENABLE:   rdata = zext_rd(DUTY_W'(en));
            default:      rdata = '0;
        endcase
    end

    assign pwm_o = en && (DUTY_W'(cnt) < active.duty);

    // R7
    hold_active_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !boundary) |=> $stable(active));

    // R6
    no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (!pending && !(we && off == OFF_DUTY)) |=> $stable(active));

    // R8
    stop_now_chk: assert property (@(posedge clk) disable iff (rst)
        (we && off == OFF_ENABLE && !wdata[0]) |=> !pwm_o);
endmodule

// File: rtl/multi_pwm.sv
module multi_pwm
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DUTY_W-1:0] wdata,
    output logic [RD_W-1:0]   rdata,
    output logic [NUM_CH-1:0] pwm_o
);
    localparam int SLOTS = 1 << CH_W;

    logic [CH_W-1:0]  ch_sel;
    logic [OFF_W-1:0] off;
    logic [SLOTS-1:0] ch_we;
    logic [RD_W-1:0]  rd_slot [SLOTS];

    assign ch_sel = addr[ADDR_W-1:OFF_W];
    assign off    = addr[OFF_W-1:0];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign ch_we[i] = we && (ch_sel == CH_W'(i));
        if (i < NUM_CH) begin : g_ch
            pwm_chan u_chan (
                .clk   (clk),
                .rst   (rst),
                .we    (ch_we[i]),
                .off   (off),
                .wdata (wdata),
                .rdata (rd_slot[i]),
                .pwm_o (pwm_o[i])
            );
        end else begin : g_empty
            assign rd_slot[i] = '0;
        end
    end

    assign rdata = rd_slot[ch_sel];

    // R10
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_we));
endmodule

// File: tb/test_multi_pwm.sv
module test_multi_pwm;
    import pwm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    multi_pwm i_multi_pwm (
        .clk(clk), .rst(rst), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
    );

    // {prescale, modulus, duty}
    localparam logic [31:0] VEC [0:6] = '{
        32'h000A_0003, 32'h0105_0002, 32'h0304_0004, 32'h0006_0000,
        32'h0203_0007, 32'h0001_0001, 32'h0408_0005
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int off, input int data);
        @(negedge clk);
        we = 1'b1; addr = 5'((ch << 3) | off); wdata = 16'(data);
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd(input int ch, input int off, output int val);
        @(negedge clk);
        addr = 5'((ch << 3) | off);
        #1 val = int'(rdata);
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_o[ch]) hi++;
        end
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, hi;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        @(negedge clk);
        check("R9 reset outputs", int'(pwm_o), 0);
        rd(0, 2, v); check("R2 reset duty", v, 0);
        rd(3, 6, v); check("R2 reset enable", v, 0);

        // vector table: configure while disabled, enable, measure two periods
        for (int i = 0; i < 7; i++) begin
            int ch = i % 4;
            int pre = int'(VEC[i][31:24]);
            int md  = int'(VEC[i][23:16]);
            int dt  = int'(VEC[i][15:0]);
            int n   = (pre + 1) * md;
            int h   = (pre + 1) * ((dt < md) ? dt : md);
            wr(ch, 0, pre);
            wr(ch, 1, md);
            wr(ch, 2, dt);
            wr(ch, 6, 1);
            count_high(ch, 2 * n, hi);
            check("R4 R5 R9 high clocks in two periods", hi, 2 * h);
            @(negedge clk);
            check("R4 next period start", int'(pwm_o[ch]), (dt > 0) ? 1 : 0);
            rd(ch, 0, v); check("R1 R2 prescale readback", v, pre);
            rd(ch, 1, v); check("R1 R2 modulus readback", v, md);
            rd(ch, 2, v); check("R2 duty readback", v, dt);
            wr(ch, 6, 0);
        end

        // R7: commit while running lands at the boundary
        wr(0, 0, 0);
        wr(0, 1, 10);
        wr(0, 2, 5);
        wr(0, 6, 1);
        wr(0, 2, 8);
        count_high(0, 9, hi);
        check("R7 running period keeps old duty", hi, 4);
        count_high(0, 10, hi);
        check("R7 next period uses new duty", hi, 8);

        // R6: modulus write alone has no effect
        wr(0, 1, 20);
        repeat (30) @(negedge clk);
        count_high(0, 20, hi);
        check("R6 modulus alone ignored", hi, 16);
        rd(0, 1, v); check("R2 staged modulus readback", v, 20);

        // R3: unmapped offsets
        wr(0, 3, 16'hFFFF);
        rd(0, 3, v); check("R3 offset 3 reads zero", v, 0);
        wr(0, 7, 16'h00AB);
        rd(0, 7, v); check("R3 offset 7 reads zero", v, 0);
        rd(0, 2, v); check("R3 duty untouched", v, 8);
        count_high(0, 20, hi);
        check("R3 output unchanged", hi, 16);

        // R10 independence and R8 immediate stop
        wr(1, 0, 0);
        wr(1, 1, 4);
        wr(1, 2, 4);
        wr(1, 6, 1);
        count_high(1, 8, hi);
        check("R10 ch1 always high", hi, 8);
        count_high(0, 10, hi);
        check("R10 ch0 unaffected by ch1", hi, 8);
        wr(1, 6, 0);
        @(negedge clk);
        check("R8 output low after disable", int'(pwm_o[1]), 0);
        rd(1, 6, v); check("R2 enable readback", v, 0);
        count_high(1, 12, hi);
        check("R9 disabled stays low", hi, 0);
        count_high(0, 10, hi);
        check("R10 ch0 still running", hi, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule